// File: doc/BRIEF.md
# Multi-Channel Pulse-Density Modulator

The block drives a bank of independent output bits. Each bit comes from a first-order sigma-delta modulator and stands in for a PWM output. Every channel holds three values: a requested duty value, an overflow modulus, and a running accumulator.

On each cycle that `step_en` is high, every channel does three things at once. It adds its request to its accumulator, compares the sum with its modulus, and emits one output bit. When the sum reaches the modulus, the bit is high and the modulus is subtracted. The remainder carries forward, so over time the fraction of high steps equals request divided by modulus. Because the high steps are spread out rather than bunched, the output changes state far more often than a PWM of the same resolution.

A plain register-write port sets the requests and moduli. It takes a channel index, a target select, 16-bit data and a strobe. A new value takes effect on the very next step, with no wait for a period boundary. The port has no back-pressure: every strobed write is accepted in the cycle it is presented.

Top module: `pdm_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every output bit, accumulator, request and modulus to zero.
- R2: On a step where a channel's modulus is nonzero and accumulator plus effective request is greater than or equal to the modulus, that channel's output becomes 1 and its accumulator becomes the sum minus the modulus. The output is registered and is visible after the stepping edge.
- R3: On a step where the modulus is nonzero and the sum is below the modulus, the output becomes 0 and the accumulator becomes the sum. The accumulator is never cleared between steps.
- R4: In a cycle with `step_en` low, no output bit and no accumulator changes.
- R5: From a zero accumulator with a constant request r no larger than modulus m, exactly r of m consecutive steps give a high output.
- R6: Channels are independent. A write or a value in one channel never changes another channel's output sequence.
- R7: A write with `wr_en` high stores `wr_data` into the request of channel `wr_ch` when `wr_sel`=0, or into its modulus when `wr_sel`=1. A write whose `wr_ch` is NCH or above changes nothing.
- R8: A write in the same cycle as a step is already used by that step for the written channel.
- R9: A request larger than the modulus is treated as equal to the modulus, so a nonzero-modulus channel then outputs 1 on every step.
- R10: A channel whose modulus is zero outputs 0 on every step and keeps its accumulator unchanged.
- R11: With an even modulus m, a request of m/2 and a zero accumulator, the output alternates 0,1,0,1,... on successive steps.
- R12: The accumulator never needs more than DW+1 bits. It stays below 2^DW even after a modulus is lowered beneath the current remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance all channels by one modulator step |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW ($clog2(NCH)) | Channel index of the write |
| wr_sel | input | 1 | Write target: 0 request, 1 modulus |
| wr_data | input | DW | Value written |
| pdm_out | output | NCH | One modulated bit per channel |

## Verification
Several properties are checked on every cycle: idle cycles hold outputs and accumulators still, a zero modulus forces a low bit, a request at or above the modulus forces a high bit, the accumulator's guard bit never sets, reset clears the state, and out-of-range writes leave the stored values unchanged. Other behaviour only shows up in the bench's scenarios, which compare every cycle against a behavioural model. These scenarios cover the exact pulse density over a full modulus, the alternating pattern at half duty, a write that coincides with a step, lowering a modulus beneath a live remainder, and the isolation between channels under random traffic.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic {
    TGT_REQ = 1'b0,
    TGT_MOD = 1'b1
  } wr_tgt_e;
endpackage

// File: rtl/pdm_regfile.sv
module pdm_regfile
  import pdm_pkg::*;
#(
  parameter int NCH = 10,
  parameter int DW  = 16,
  parameter int CHW = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [CHW-1:0]          wr_ch,
  input  logic                    wr_sel,
  input  logic [DW-1:0]           wr_data,
  output logic [NCH-1:0][DW-1:0]  req_eff,
  output logic [NCH-1:0][DW-1:0]  mod_eff
);
  logic [NCH-1:0][DW-1:0] req_q;
  logic [NCH-1:0][DW-1:0] mod_q;
  logic                   wr_req_hit [NCH];
  logic                   wr_mod_hit [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      wr_req_hit[c] = wr_en && (int'(wr_ch) == c) && (wr_tgt_e'(wr_sel) == TGT_REQ);
      wr_mod_hit[c] = wr_en && (int'(wr_ch) == c) && (wr_tgt_e'(wr_sel) == TGT_MOD);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[c] <= '0;
        mod_q[c] <= '0;
      end else begin
        if (wr_req_hit[c]) req_q[c] <= wr_data;
        if (wr_mod_hit[c]) mod_q[c] <= wr_data;
      end
    end

    // bypass: a write coinciding with a step is seen by that step
    assign req_eff[c] = wr_req_hit[c] ? wr_data : req_q[c];
    assign mod_eff[c] = wr_mod_hit[c] ? wr_data : mod_q[c];
  end

  // R7: a write aimed past the last channel leaves all stored values alone
  p_bad_index_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_ch) >= NCH) |=> ($stable(req_q) && $stable(mod_q)));
endmodule

// File: rtl/pdm_chan.sv
module pdm_chan #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic [DW-1:0] req,
  input  logic [DW-1:0] modulus,
  output logic          bit_o
);
  logic [DW:0]   acc_q;
  logic [DW-1:0] req_c;
  logic [DW:0]   sum;
  logic          reach;
  logic          mod_zero;

  always_comb begin
    req_c    = (req > modulus) ? modulus : req;
    sum      = acc_q + {1'b0, req_c};
    mod_zero = (modulus == '0);
    reach    = (sum >= {1'b0, modulus});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      bit_o <= 1'b0;
    end else if (step_en) begin
      if (mod_zero) begin
        bit_o <= 1'b0;
      end else if (reach) begin
        bit_o <= 1'b1;
        acc_q <= sum - {1'b0, modulus};
      end else begin
        bit_o <= 1'b0;
        acc_q <= sum;
      end
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (bit_o == 1'b0 && acc_q == '0));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(bit_o) && $stable(acc_q)));
  p_zero_mod_low_r10: assert property (@(posedge clk) disable iff (rst)
    (step_en && modulus == '0) |=> (bit_o == 1'b0 && $stable(acc_q)));
  p_full_req_high_r9: assert property (@(posedge clk) disable iff (rst)
    (step_en && modulus != '0 && req >= modulus) |=> bit_o);
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    acc_q[DW] == 1'b0);
endmodule

// File: rtl/pdm_bank.sv
module pdm_bank #(
  parameter int NCH = 10,
  parameter int DW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_en,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic           wr_sel,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pdm_out
);
  logic [NCH-1:0][DW-1:0] req_eff;
  logic [NCH-1:0][DW-1:0] mod_eff;

  pdm_regfile #(.NCH(NCH), .DW(DW), .CHW(CHW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .req_eff (req_eff),
    .mod_eff (mod_eff)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_mod
    pdm_chan #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .step_en (step_en),
      .req     (req_eff[c]),
      .modulus (mod_eff[c]),
      .bit_o   (pdm_out[c])
    );
  end
endmodule

// File: tb/pdm_bank_tb.sv
module pdm_bank_tb;
  localparam int NCH = 10;
  localparam int DW  = 16;
  localparam int CHW = $clog2(NCH);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           step_en = 1'b0;
  logic           wr_en = 1'b0;
  logic [CHW-1:0] wr_ch = '0;
  logic           wr_sel = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic [NCH-1:0] pdm_out;

  int compared = 0;
  int mismatched = 0;
  bit armed = 1'b0;
  bit done = 1'b0;
  string phase = "R1";

  longint m_req [NCH];
  longint m_mod [NCH];
  longint m_acc [NCH];
  bit     m_out [NCH];

  always #5 clk = ~clk;

  pdm_bank #(.NCH(NCH), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .wr_en(wr_en),
    .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data), .pdm_out(pdm_out)
  );

  // behavioural reference, advanced on each rising edge from the inputs alone
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_req[c] = 0; m_mod[c] = 0; m_acc[c] = 0; m_out[c] = 0;
      end
    end else begin
      if (wr_en && int'(wr_ch) < NCH) begin
        if (wr_sel) m_mod[wr_ch] = wr_data;
        else        m_req[wr_ch] = wr_data;
      end
      if (step_en) begin
        for (int c = 0; c < NCH; c++) begin
          longint r;
          longint s;
          if (m_mod[c] == 0) begin
            m_out[c] = 0;
          end else begin
            r = (m_req[c] > m_mod[c]) ? m_mod[c] : m_req[c];
            s = m_acc[c] + r;
            if (s >= m_mod[c]) begin m_out[c] = 1; m_acc[c] = s - m_mod[c]; end
            else               begin m_out[c] = 0; m_acc[c] = s; end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      for (int c = 0; c < NCH; c++) begin
        compared++;
        if (pdm_out[c] !== m_out[c]) begin
          mismatched++;
          $display("FAIL %s ch%0d t=%0t: pdm_out=%b expected %b", phase, c, $time, pdm_out[c], m_out[c]);
        end
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // all drive tasks start and end at a falling edge
  task automatic cycle(input bit stp);
    step_en = stp;
    @(negedge clk);
    step_en = 1'b0;
  endtask

  task automatic wr(input int ch, input bit sel, input int val, input bit stp);
    wr_en = 1'b1; wr_ch = CHW'(ch); wr_sel = sel; wr_data = DW'(val); step_en = stp;
    @(negedge clk);
    wr_en = 1'b0; step_en = 1'b0;
  endtask

  initial begin
    int ones;
    bit prev;
    @(negedge clk);
    @(negedge clk);
    armed = 1'b1;
    rst = 1'b0;
    check("R1 reset outputs", longint'(pdm_out), 0);

    // per-channel setup (R7, R6); no steps yet
    phase = "R7";
    wr(0, 1, 10, 0);   wr(0, 0, 3, 0);
    wr(1, 1, 7, 0);    wr(1, 0, 7, 0);
    wr(2, 1, 200, 0);  wr(2, 0, 300, 0);   // clamped
    wr(3, 1, 0, 0);    wr(3, 0, 5, 0);     // zero modulus
    wr(4, 1, 100, 0);  wr(4, 0, 50, 0);    // half duty
    wr(5, 1, 1000, 0); wr(5, 0, 999, 0);
    for (int c = 6; c < NCH; c++) begin
      wr(c, 1, 60000 + c, 0); wr(c, 0, 12345 * c, 0);
    end
    check("R4 no step keeps outputs low", longint'(pdm_out), 0);

    // R2/R3/R5/R9/R10/R11 over one period of channel 0
    phase = "R2/R3";
    ones = 0;
    prev = 1'b1;
    for (int k = 0; k < 10; k++) begin
      cycle(1);
      ones += pdm_out[0];
      check("R9 clamped request always high", pdm_out[2], 1);
      check("R10 zero modulus always low", pdm_out[3], 0);
      check("R11 half duty alternates", pdm_out[4], !prev);
      prev = pdm_out[4];
    end
    check("R5 density 3 of 10", ones, 3);

    // R4: idle cycles interleaved with steps
    phase = "R4";
    for (int k = 0; k < 30; k++) cycle(k % 3 == 0);

    // R8: write in a step cycle changes that very step
    phase = "R8";
    wr(1, 0, 0, 1);
    check("R8 request zero used at once", pdm_out[1], 0);
    wr(1, 0, 7, 1);
    check("R8 full request used at once", pdm_out[1], 1);

    // R12: shrink a modulus under a live remainder
    phase = "R12";
    for (int k = 0; k < 5; k++) cycle(1);
    wr(5, 1, 3, 1);
    for (int k = 0; k < 20; k++) cycle(1);

    // R7: out-of-range index has no effect
    phase = "R7";
    wr(12, 1, 1, 1);
    wr(15, 0, 65535, 1);
    for (int k = 0; k < 10; k++) cycle(1);

    // R6: random traffic, every channel compared each cycle
    phase = "R6";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(3) == 0) begin
        int v;
        v = ($urandom_range(1) == 0) ? int'($urandom_range(20)) : int'($urandom_range(65535));
        wr(int'($urandom_range(15)), 1'($urandom_range(1)), v, 1'($urandom_range(1)));
      end else begin
        cycle(1'($urandom_range(1)));
      end
    end

    // R1: reset mid-run
    phase = "R1";
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", longint'(pdm_out), 0);
    wr(0, 1, 4, 0);
    for (int k = 0; k < 4; k++) cycle(1);   // modulus set, request zero after reset
    check("R1 request cleared by reset", longint'(pdm_out), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule